// File: doc/BRIEF.md
# Unaligned Word Merge Unit

This block carries out the four partial-word memory operations that let software move a 32-bit value to or from an address that is not word aligned. A pair of them, one "left" and one "right", covers a full misaligned word between them. Each operation reads the aligned memory word that contains the addressed byte. It then combines bytes of that word with bytes of a register value, choosing the split from the low two address bits. Byte order is little-endian and cannot be changed.

For the two load forms, the combined word is written to the destination register through a write port that is valid for one cycle. For the two store forms, the block writes the combined word back to the same aligned address as a read-modify-write. It accepts one request at a time. It issues a single-cycle read strobe, waits for read data to return with any latency, and finishes with a one-cycle done pulse. The reset input is asynchronous; the unit releases it internally in step with the clock.

Top module: `uaw_merge_unit`

## Requirements
- R1: After reset, busy, done, mem_rd_en, mem_wr_en and rf_we are all 0.
- R2: The cycle after a request is accepted, mem_rd_en is 1 for exactly one cycle. mem_addr equals req_addr with bits [1:0] forced to 0, during that read and also during any later write. The offset o is req_addr[1:0].
- R3: Left load (req_op = 2'b00) yields these results for o = 0, 1, 2, 3: (mem<<24)|(reg&32'h00FFFFFF), (mem<<16)|(reg&32'h0000FFFF), (mem<<8)|(reg&32'h000000FF), and mem.
- R4: Right load (req_op = 2'b01) yields these results for o = 0, 1, 2, 3: mem, (mem>>8)|(reg&32'hFF000000), (mem>>16)|(reg&32'hFFFF0000), and (mem>>24)|(reg&32'hFFFFFF00).
- R5: Left store (req_op = 2'b10) writes these words for o = 0, 1, 2, 3: (reg>>24)|(mem&32'hFFFFFF00), (reg>>16)|(mem&32'hFFFF0000), (reg>>8)|(mem&32'hFF000000), and reg.
- R6: Right store (req_op = 2'b11) writes these words for o = 0, 1, 2, 3: reg, (reg<<8)|(mem&32'h000000FF), (reg<<16)|(mem&32'h0000FFFF), and (reg<<24)|(mem&32'h00FFFFFF).
- R7: For a load, done and rf_we are both 1 in the cycle after the cycle in which mem_rvalid was sampled 1. In that same cycle, rf_wdata holds the merged value and rf_waddr equals req_dest. No memory write takes place.
- R8: A load with req_dest = 0 still issues the memory read and still pulses done, but rf_we stays 0.
- R9: For a store, mem_wr_en is 1 for one cycle, in the cycle after mem_rvalid was sampled 1, with mem_wdata carrying the merged word. done follows in the next cycle. rf_we stays 0 throughout.
- R10: While busy is 1, req_valid has no effect on the operation in progress. mem_rvalid has no effect except while the unit is waiting for read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is 0 |
| req_op | input | 2 | 00 left load, 01 right load, 10 left store, 11 right store |
| req_addr | input | 32 | Effective byte address |
| req_reg | input | 32 | Current register value |
| req_dest | input | 5 | Destination register index for loads |
| busy | output | 1 | An operation is in progress |
| mem_rd_en | output | 1 | One-cycle read strobe |
| mem_wr_en | output | 1 | One-cycle write strobe |
| mem_addr | output | 32 | Aligned word address |
| mem_wdata | output | 32 | Merged word for stores |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Aligned word read from memory |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 5 | Register write index |
| rf_wdata | output | 32 | Merged register value |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a new request or a stray read-valid arriving while an operation is already under way. A correct design leaves no trace of either at the result ports, so a check can only catch the fault if the disturbing input differs sharply from the real one. The bench therefore stretches the read latency to several cycles and raises req_valid inside that wait, with the opposite operation type and a different address and register value. It also pulses mem_rvalid while the unit is idle. It then confirms that the strobes, address, data and done timing all still match the original request. Every operation is run at all four offsets with varied data, so that every byte lane is taken from memory and from the register at least once.

// File: rtl/uaw_pkg.sv
package uaw_pkg;

  typedef enum logic [1:0] {
    OP_LOAD_LEFT   = 2'b00,
    OP_LOAD_RIGHT  = 2'b01,
    OP_STORE_LEFT  = 2'b10,
    OP_STORE_RIGHT = 2'b11
  } uaw_op_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_WAIT   = 3'd2,
    ST_WRITE  = 3'd3,
    ST_FINISH = 3'd4
  } uaw_state_e;

  function automatic logic op_is_store(uaw_op_e op);
    return op[1];
  endfunction

endpackage

// File: rtl/uaw_rst_sync.sv
module uaw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;
endmodule

// File: rtl/uaw_byte_merge.sv
module uaw_byte_merge
  import uaw_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  uaw_op_e             op,
  input  logic [OFF_W-1:0]    offset,
  input  logic [DATA_W-1:0]   mem_word,
  input  logic [DATA_W-1:0]   reg_word,
  output logic [DATA_W-1:0]   merged
);
  localparam logic [OFF_W:0] LAST = (OFF_W+1)'(BYTES - 1);

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    localparam logic [OFF_W:0] LANE = (OFF_W+1)'(g);
    logic [OFF_W:0]   off_x;
    logic [OFF_W:0]   sum_x;
    logic [OFF_W-1:0] idx;
    logic             pick_mem;
    logic [7:0]       lane_byte;

    always_comb begin
      off_x    = {1'b0, offset};
      sum_x    = LANE + off_x;
      idx      = '0;
      pick_mem = 1'b0;
      unique case (op)
        OP_LOAD_LEFT: begin
          pick_mem = (sum_x >= LAST);
          idx      = OFF_W'(sum_x + (OFF_W+1)'(1));
        end
        OP_LOAD_RIGHT: begin
          pick_mem = (sum_x <= LAST);
          idx      = OFF_W'(sum_x);
        end
        OP_STORE_LEFT: begin
          pick_mem = (LANE > off_x);
          idx      = OFF_W'(LANE - off_x - (OFF_W+1)'(1));
        end
        OP_STORE_RIGHT: begin
          pick_mem = (LANE < off_x);
          idx      = OFF_W'(LANE - off_x);
        end
        default: begin
          pick_mem = 1'b0;
          idx      = '0;
        end
      endcase

      if (!op_is_store(op)) begin
        lane_byte = pick_mem ? mem_word[{idx, 3'b000} +: 8] : reg_word[8*g +: 8];
      end else begin
        lane_byte = pick_mem ? mem_word[8*g +: 8] : reg_word[{idx, 3'b000} +: 8];
      end
    end

    assign merged[8*g +: 8] = lane_byte;
  end
endmodule

// File: rtl/uaw_seq_ctrl.sv
module uaw_seq_ctrl
  import uaw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  uaw_op_e           req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_reg,
  input  logic [IDX_W-1:0]  req_dest,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_waddr,
  output logic              done,
  output uaw_op_e           op_q,
  output logic [OFF_W-1:0]  off_q,
  output logic [DATA_W-1:0] reg_q,
  output logic [DATA_W-1:0] mem_q
);
  uaw_state_e        state_q, state_d;
  logic              accept;
  logic              capture;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  dest_q;

  // next state
  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    capture = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          state_d = ST_READ;
        end
      end
      ST_READ: state_d = ST_WAIT;
      ST_WAIT: begin
        if (mem_rvalid) begin
          capture = 1'b1;
          state_d = op_is_store(op_q) ? ST_WRITE : ST_FINISH;
        end
      end
      ST_WRITE:  state_d = ST_FINISH;
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // request capture, enabled by accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_LOAD_LEFT;
      off_q  <= '0;
      addr_q <= '0;
      reg_q  <= '0;
      dest_q <= '0;
    end else if (accept) begin
      op_q   <= req_op;
      off_q  <= req_addr[OFF_W-1:0];
      addr_q <= {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      reg_q  <= req_reg;
      dest_q <= req_dest;
    end
  end

  // read data capture, enabled by capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (capture) begin
      mem_q <= mem_rdata;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign mem_rd_en = (state_q == ST_READ);
  assign mem_wr_en = (state_q == ST_WRITE);
  assign mem_addr  = addr_q;
  assign done      = (state_q == ST_FINISH);
  assign rf_we     = done && !op_is_store(op_q) && (dest_q != '0);
  assign rf_waddr  = dest_q;

  p_read_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en || mem_wr_en) |-> (mem_addr[OFF_W-1:0] == '0));

  p_load_finish_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && mem_rvalid && !op_q[1]) |=> (done && !mem_wr_en));

  p_store_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> (done && !rf_we));

  p_zero_dest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_waddr != '0));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> ($stable(addr_q) && $stable(op_q) && $stable(reg_q)));
endmodule

// File: rtl/uaw_merge_unit.sv
module uaw_merge_unit
  import uaw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_reg,
  input  logic [IDX_W-1:0]  req_dest,
  output logic              busy,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              done
);
  logic              rst_n_sync;
  uaw_op_e           op_q;
  logic [OFF_W-1:0]  off_q;
  logic [DATA_W-1:0] reg_q;
  logic [DATA_W-1:0] mem_q;
  logic [DATA_W-1:0] merged;

  uaw_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  uaw_seq_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .req_valid  (req_valid),
    .req_op     (uaw_op_e'(req_op)),
    .req_addr   (req_addr),
    .req_reg    (req_reg),
    .req_dest   (req_dest),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .busy       (busy),
    .mem_rd_en  (mem_rd_en),
    .mem_wr_en  (mem_wr_en),
    .mem_addr   (mem_addr),
    .rf_we      (rf_we),
    .rf_waddr   (rf_waddr),
    .done       (done),
    .op_q       (op_q),
    .off_q      (off_q),
    .reg_q      (reg_q),
    .mem_q      (mem_q)
  );

  uaw_byte_merge #(
    .DATA_W (DATA_W)
  ) u_merge (
    .op       (op_q),
    .offset   (off_q),
    .mem_word (mem_q),
    .reg_word (reg_q),
    .merged   (merged)
  );

  assign mem_wdata = merged;
  assign rf_wdata  = merged;

  p_full_left_load_r3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (done && op_q == OP_LOAD_LEFT && off_q == OFF_W'(BYTES - 1)) |-> (rf_wdata == mem_q));

  p_full_right_load_r4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (done && op_q == OP_LOAD_RIGHT && off_q == '0) |-> (rf_wdata == mem_q));

  p_full_left_store_r5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (mem_wr_en && op_q == OP_STORE_LEFT && off_q == OFF_W'(BYTES - 1)) |-> (mem_wdata == reg_q));

  p_full_right_store_r6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (mem_wr_en && op_q == OP_STORE_RIGHT && off_q == '0) |-> (mem_wdata == reg_q));
endmodule

// File: tb/tb_uaw_merge_unit.sv
module tb_uaw_merge_unit;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_op;
  logic [31:0] req_addr;
  logic [31:0] req_reg;
  logic [4:0]  req_dest;
  logic        busy;
  logic        mem_rd_en;
  logic        mem_wr_en;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        rf_we;
  logic [4:0]  rf_waddr;
  logic [31:0] rf_wdata;
  logic        done;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [31:0] seed = 32'h1234_5678;

  uaw_merge_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_reg(req_reg), .req_dest(req_dest),
    .busy(busy), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog act=%0d exp<=100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return {seed[15:0], seed[31:16]} ^ (seed << 3);
  endfunction

  // expected merge, written from the requirement formulas
  function automatic logic [31:0] expect_word(input logic [1:0] op, input logic [1:0] o,
                                             input logic [31:0] m, input logic [31:0] r);
    logic [31:0] res;
    res = '0;
    case (op)
      2'b00: case (o)   // R3
        2'd0: res = (m << 24) | (r & 32'h00FFFFFF);
        2'd1: res = (m << 16) | (r & 32'h0000FFFF);
        2'd2: res = (m << 8)  | (r & 32'h000000FF);
        default: res = m;
      endcase
      2'b01: case (o)   // R4
        2'd0: res = m;
        2'd1: res = (m >> 8)  | (r & 32'hFF000000);
        2'd2: res = (m >> 16) | (r & 32'hFFFF0000);
        default: res = (m >> 24) | (r & 32'hFFFFFF00);
      endcase
      2'b10: case (o)   // R5
        2'd0: res = (r >> 24) | (m & 32'hFFFFFF00);
        2'd1: res = (r >> 16) | (m & 32'hFFFF0000);
        2'd2: res = (r >> 8)  | (m & 32'hFF000000);
        default: res = r;
      endcase
      default: case (o) // R6
        2'd0: res = r;
        2'd1: res = (r << 8)  | (m & 32'h000000FF);
        2'd2: res = (r << 16) | (m & 32'h0000FFFF);
        default: res = (r << 24) | (m & 32'h00FFFFFF);
      endcase
    endcase
    return res;
  endfunction

  function automatic string op_tag(input logic [1:0] op);
    case (op)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [31:0] addr, input logic [31:0] regv,
                        input logic [4:0] dest, input logic [31:0] memv, input int lat,
                        input bit disturb);
    logic [31:0] exp;
    exp = expect_word(op, addr[1:0], memv, regv);
    @(negedge clk);
    chk("R10 idle before request", {31'd0, busy}, 32'd0);
    req_valid = 1'b1;
    req_op    = op;
    req_addr  = addr;
    req_reg   = regv;
    req_dest  = dest;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 read strobe", {31'd0, mem_rd_en}, 32'd1);
    chk("R2 aligned read address", mem_addr, {addr[31:2], 2'b00});
    chk("R7 no early done", {31'd0, done}, 32'd0);
    for (int k = 0; k <= lat; k++) begin
      @(negedge clk);
      if (k < lat) begin
        chk("R2 single read pulse", {31'd0, mem_rd_en}, 32'd0);
        chk("R9 no write while waiting", {31'd0, mem_wr_en}, 32'd0);
        chk("R10 busy while waiting", {31'd0, busy}, 32'd1);
        if (disturb && k == 0) begin
          req_valid = 1'b1;
          req_op    = ~op;
          req_addr  = ~addr;
          req_reg   = ~regv;
          req_dest  = ~dest;
        end else begin
          req_valid = 1'b0;
        end
      end else begin
        req_valid  = 1'b0;
        mem_rvalid = 1'b1;
        mem_rdata  = memv;
      end
    end
    @(negedge clk);
    mem_rvalid = 1'b0;
    mem_rdata  = ~memv;
    if (!op[1]) begin
      chk("R7 done after data", {31'd0, done}, 32'd1);
      chk("R7 no memory write on load", {31'd0, mem_wr_en}, 32'd0);
      if (dest != 5'd0) begin
        chk("R7 register write enable", {31'd0, rf_we}, 32'd1);
        chk("R7 register index", {27'd0, rf_waddr}, {27'd0, dest});
      end else begin
        chk("R8 zero destination not written", {31'd0, rf_we}, 32'd0);
      end
      chk(op_tag(op), rf_wdata, exp);
    end else begin
      chk("R9 write strobe", {31'd0, mem_wr_en}, 32'd1);
      chk("R9 aligned write address", mem_addr, {addr[31:2], 2'b00});
      chk(op_tag(op), mem_wdata, exp);
      chk("R9 done waits for write", {31'd0, done}, 32'd0);
      chk("R9 no register write", {31'd0, rf_we}, 32'd0);
      @(negedge clk);
      chk("R9 done after write", {31'd0, done}, 32'd1);
      chk("R9 single write pulse", {31'd0, mem_wr_en}, 32'd0);
      chk("R9 no register write at done", {31'd0, rf_we}, 32'd0);
    end
    @(negedge clk);
    chk("R7 done is one cycle", {31'd0, done}, 32'd0);
    chk("R10 idle after completion", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    rst_n      = 1'b0;
    req_valid  = 1'b0;
    req_op     = 2'b00;
    req_addr   = '0;
    req_reg    = '0;
    req_dest   = '0;
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 read strobe", {31'd0, mem_rd_en}, 32'd0);
    chk("R1 write strobe", {31'd0, mem_wr_en}, 32'd0);
    chk("R1 register write", {31'd0, rf_we}, 32'd0);

    // fixed patterns: every operation at every offset
    for (int op = 0; op < 4; op++) begin
      for (int o = 0; o < 4; o++) begin
        run_op(2'(op), 32'h0000_1000 + 32'(o), 32'hAABB_CCDD, 5'd9, 32'h1122_3344, 1, 1'b0);
      end
    end

    // varied data and latencies, some with disturbing requests
    for (int n = 0; n < 40; n++) begin
      logic [31:0] a;
      logic [31:0] r;
      logic [31:0] m;
      a = next_rand();
      r = next_rand();
      m = next_rand();
      run_op(2'(n % 4), a, r, 5'(1 + (n % 31)), m, n % 5, (n % 3) == 0);
    end

    // R8: zero destination, both load kinds
    run_op(2'b00, 32'h0000_2002, 32'h5555_AAAA, 5'd0, 32'hDEAD_BEEF, 2, 1'b0);
    run_op(2'b01, 32'h0000_2001, 32'h5555_AAAA, 5'd0, 32'hDEAD_BEEF, 0, 1'b0);

    // R10: stray read-valid while idle
    @(negedge clk);
    mem_rvalid = 1'b1;
    mem_rdata  = 32'hFFFF_FFFF;
    @(negedge clk);
    chk("R10 stray rvalid busy", {31'd0, busy}, 32'd0);
    chk("R10 stray rvalid done", {31'd0, done}, 32'd0);
    @(negedge clk);
    mem_rvalid = 1'b0;
    chk("R10 stray rvalid no strobe", {30'd0, mem_rd_en, mem_wr_en}, 32'd0);
    chk("R10 stray rvalid no register write", {31'd0, rf_we}, 32'd0);
    run_op(2'b11, 32'h0000_3003, 32'h0102_0304, 5'd4, 32'hA0B0_C0D0, 3, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule